// File: doc/BRIEF.md
# Software Trap Vector Unit

This block serves the trap instruction of a 32-bit processor. Privileged software loads a trap base register that holds the upper part of a handler table address. When the pipeline reports an executing trap, the block adds the trap's register operand to its sign-extended immediate. The low seven bits of that sum become a trap number. The number is spliced into the table base to form the handler address. The table holds one slot of four 32-bit instructions per trap number.

On a trap the block pulses a redirect toward the fetch unit with the handler address and enters privileged mode. It also records the address of the instruction after the trap, so the handler can later come back to it. The trap is the last instruction that completes, and the redirect pulse is what the pipeline uses to squash everything younger. A return-from-trap strobe drops back to user mode and redirects fetch to the recorded address. Any attempt to load the base register from user mode is refused and flagged.

Top module: `trap_vector_unit`

## Requirements
- R1: After reset the unit is in privileged mode (`priv_mode` = 1), `redirect` and `priv_violation` are 0, and the base register is zero, so a trap with number N vectors to address N*16.
- R2: A trap's target address has bits 31..12 equal to the base register, bit 11 zero, bits 10..4 equal to bits 6..0 of (operand + sign-extended 13-bit immediate), and bits 3..0 zero. The sum wraps modulo 128.
- R3: The cycle after `trap_valid` is sampled high, `redirect` is 1 for that one cycle and `redirect_target` holds the handler address. With no new event, `redirect` is 0 in the following cycle.
- R4: A trap sets `priv_mode` to 1 from the cycle after it, whatever the previous mode was.
- R5: A trap loads `saved_pc` with `trap_pc` + 4 in the same cycle that the redirect appears. `saved_pc` keeps that value until the next trap.
- R6: A base write in privileged mode loads bits 31..12 of `base_wr_data` into the base register and discards bits 11..0. Traps from the next cycle onward use the new base.
- R7: A base write in user mode leaves the base register unchanged. `priv_violation` is 1 for exactly the following cycle.
- R8: A return-from-trap in privileged mode gives, one cycle later, a one-cycle `redirect` with `redirect_target` equal to `saved_pc`, and `priv_mode` becomes 0.
- R9: A return-from-trap in user mode has no effect: no redirect, and the mode and `saved_pc` are unchanged.
- R10: When a trap and a return-from-trap arrive in the same cycle, the trap is taken and the return is ignored.
- R11: When a trap and a base write arrive in the same cycle, the trap uses the base value from before the write. The write is judged against the mode from before the trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap instruction executes this cycle |
| trap_operand | input | 32 | Register operand of the trap |
| trap_imm | input | 13 | Signed immediate of the trap |
| trap_pc | input | 32 | Address of the trap instruction |
| base_wr_en | input | 1 | Request to load the trap base register |
| base_wr_data | input | 32 | Value for the base register (upper 20 bits used) |
| rett_valid | input | 1 | Return-from-trap strobe |
| redirect | output | 1 | One-cycle fetch redirect and younger-instruction squash |
| redirect_target | output | 32 | Fetch address that goes with `redirect` |
| priv_mode | output | 1 | 1 = privileged, 0 = user |
| saved_pc | output | 32 | Return address recorded at the last trap |
| priv_violation | output | 1 | One-cycle flag for a refused user-mode base write |

## Verification
Every result is registered once, so the redirect, target, mode, saved address and violation flag caused by inputs sampled at one rising edge all show at that edge. A base write only affects traps from the next edge onward. The bench drives inputs on the falling edge and samples all outputs on the falling edge that follows the next rising edge. A reference model advances by one step per cycle, so every comparison is made against the state the requirements give for exactly that cycle.

// File: rtl/tvu_pkg.sv
`timescale 1ns/1ps
package tvu_pkg;
   typedef enum logic {
      MODE_USER = 1'b0,
      MODE_PRIV = 1'b1
   } tvu_mode_e;

   typedef struct packed {
      logic take_trap;
      logic take_return;
   } tvu_evt_t;
endpackage

// File: rtl/tvu_base_reg.sv
`timescale 1ns/1ps
module tvu_base_reg #(
   parameter int XLEN   = 32,
   parameter int BASE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_i,
   input  logic              wr_en_i,
   input  logic [XLEN-1:0]   wr_data_i,
   output logic [BASE_W-1:0] base_o,
   output logic              viol_o
);
   localparam int LOW_W = XLEN - BASE_W;

   generate
      if (BASE_W < 1 || BASE_W >= XLEN) begin : g_bad_width
         $error("tvu_base_reg: BASE_W must lie in 1..XLEN-1");
      end
   endgenerate

   logic [BASE_W-1:0] base_q;
   logic              viol_q;
   logic              wr_ok;
   logic              wr_refused;
   logic              unused_wr_low;

   assign wr_ok         = wr_en_i &  priv_i;
   assign wr_refused    = wr_en_i & ~priv_i;
   assign unused_wr_low = ^wr_data_i[LOW_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         viol_q <= 1'b0;
      end else begin
         viol_q <= wr_refused;
         if (wr_ok) begin
            base_q <= wr_data_i[XLEN-1:LOW_W];
         end
      end
   end

   assign base_o = base_q;
   assign viol_o = viol_q;

   a_r6_priv_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && priv_i) |=> (base_q == $past(wr_data_i[XLEN-1:LOW_W])));

   a_r7_user_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !priv_i) |=> (viol_o && $stable(base_q)));

   a_r7_flag_only_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && !priv_i) |=> !viol_o);
endmodule

// File: rtl/tvu_vector_gen.sv
`timescale 1ns/1ps
module tvu_vector_gen #(
   parameter int XLEN     = 32,
   parameter int IMM_W    = 13,
   parameter int NUM_W    = 7,
   parameter int SLOT_LSB = 4,
   parameter int BASE_W   = 20
) (
   input  logic [BASE_W-1:0] base_i,
   input  logic [XLEN-1:0]   operand_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [NUM_W-1:0]  trap_num_o,
   output logic [XLEN-1:0]   vector_o
);
   localparam int GAP_W = XLEN - BASE_W - NUM_W - SLOT_LSB;

   generate
      if (GAP_W < 0) begin : g_bad_split
         $error("tvu_vector_gen: base, number and slot fields exceed XLEN");
      end
      if (NUM_W < 1 || NUM_W > XLEN) begin : g_bad_num
         $error("tvu_vector_gen: NUM_W out of range");
      end
   endgenerate

   logic [NUM_W-1:0] imm_n;
   logic [NUM_W-1:0] op_n;
   logic             unused_op_hi;
   logic             unused_imm_hi;

   generate
      if (IMM_W >= NUM_W) begin : g_imm_trunc
         assign imm_n = imm_i[NUM_W-1:0];
         if (IMM_W > NUM_W) begin : g_imm_hi
            assign unused_imm_hi = ^imm_i[IMM_W-1:NUM_W];
         end else begin : g_imm_nohi
            assign unused_imm_hi = 1'b0;
         end
      end else begin : g_imm_sext
         assign imm_n         = {{(NUM_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
         assign unused_imm_hi = 1'b0;
      end

      if (XLEN > NUM_W) begin : g_op_hi
         assign unused_op_hi = ^operand_i[XLEN-1:NUM_W];
      end else begin : g_op_nohi
         assign unused_op_hi = 1'b0;
      end
   endgenerate

   assign op_n       = operand_i[NUM_W-1:0];
   assign trap_num_o = op_n + imm_n;

   generate
      if (GAP_W > 0) begin : g_with_gap
         assign vector_o = {base_i, {GAP_W{1'b0}}, trap_num_o, {SLOT_LSB{1'b0}}};
      end else begin : g_no_gap
         assign vector_o = {base_i, trap_num_o, {SLOT_LSB{1'b0}}};
      end
   endgenerate

   always_comb begin
      a_r2_slot_low_zero: assert (vector_o[SLOT_LSB-1:0] == '0);
   end
endmodule

// File: rtl/tvu_mode_ctrl.sv
`timescale 1ns/1ps
module tvu_mode_ctrl
   import tvu_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trap_i,
   input  logic            rett_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] vector_i,
   output logic            priv_o,
   output logic [XLEN-1:0] saved_pc_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] target_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   generate
      if (INSN_BYTES < 1) begin : g_bad_step
         $error("tvu_mode_ctrl: INSN_BYTES must be positive");
      end
   endgenerate

   tvu_mode_e       mode_q;
   logic [XLEN-1:0] saved_q;
   logic            redir_q;
   logic [XLEN-1:0] target_q;
   tvu_evt_t        evt;

   always_comb begin
      evt.take_trap   = trap_i;
      evt.take_return = rett_i & ~trap_i & (mode_q == MODE_PRIV);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= MODE_PRIV;
         saved_q  <= '0;
         redir_q  <= 1'b0;
         target_q <= '0;
      end else begin
         redir_q <= evt.take_trap | evt.take_return;
         if (evt.take_trap) begin
            mode_q   <= MODE_PRIV;
            saved_q  <= pc_i + STEP;
            target_q <= vector_i;
         end else if (evt.take_return) begin
            mode_q   <= MODE_USER;
            target_q <= saved_q;
         end
      end
   end

   assign priv_o     = (mode_q == MODE_PRIV);
   assign saved_pc_o = saved_q;
   assign redirect_o = redir_q;
   assign target_o   = target_q;

   a_r3_trap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (redirect_o && target_o == $past(vector_i)));

   a_r4_trap_enters_priv: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> priv_o);

   a_r5_saved_pc_next: assert property (@(posedge clk) disable iff (!rst_n)
      trap_i |=> (saved_pc_o == $past(pc_i) + STEP));

   a_r5_saved_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_i |=> $stable(saved_pc_o));

   a_r8_return_to_user: assert property (@(posedge clk) disable iff (!rst_n)
      (rett_i && !trap_i && priv_o) |=> (!priv_o && redirect_o && target_o == $past(saved_pc_o)));

   a_r9_user_return_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (rett_i && !trap_i && !priv_o) |=> (!redirect_o && !priv_o));

   a_r3_no_spurious_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_i && !rett_i) |=> !redirect_o);
endmodule

// File: rtl/trap_vector_unit.sv
`timescale 1ns/1ps
module trap_vector_unit #(
   parameter int XLEN       = 32,
   parameter int IMM_W      = 13,
   parameter int NUM_W      = 7,
   parameter int SLOT_LSB   = 4,
   parameter int BASE_W     = 20,
   parameter int INSN_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trap_valid,
   input  logic [XLEN-1:0]  trap_operand,
   input  logic [IMM_W-1:0] trap_imm,
   input  logic [XLEN-1:0]  trap_pc,
   input  logic             base_wr_en,
   input  logic [XLEN-1:0]  base_wr_data,
   input  logic             rett_valid,
   output logic             redirect,
   output logic [XLEN-1:0]  redirect_target,
   output logic             priv_mode,
   output logic [XLEN-1:0]  saved_pc,
   output logic             priv_violation
);
   localparam int SLOT_BYTES = 1 << SLOT_LSB;

   generate
      if (SLOT_BYTES % INSN_BYTES != 0) begin : g_bad_slot
         $error("trap_vector_unit: a slot must hold whole instructions");
      end
   endgenerate

   logic [BASE_W-1:0] base_w;
   logic [XLEN-1:0]   vector_w;
   logic [NUM_W-1:0]  trap_num_w;
   logic              priv_w;

   tvu_base_reg #(
      .XLEN   (XLEN),
      .BASE_W (BASE_W)
   ) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .priv_i    (priv_w),
      .wr_en_i   (base_wr_en),
      .wr_data_i (base_wr_data),
      .base_o    (base_w),
      .viol_o    (priv_violation)
   );

   tvu_vector_gen #(
      .XLEN     (XLEN),
      .IMM_W    (IMM_W),
      .NUM_W    (NUM_W),
      .SLOT_LSB (SLOT_LSB),
      .BASE_W   (BASE_W)
   ) u_vec (
      .base_i     (base_w),
      .operand_i  (trap_operand),
      .imm_i      (trap_imm),
      .trap_num_o (trap_num_w),
      .vector_o   (vector_w)
   );

   tvu_mode_ctrl #(
      .XLEN       (XLEN),
      .INSN_BYTES (INSN_BYTES)
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_i     (trap_valid),
      .rett_i     (rett_valid),
      .pc_i       (trap_pc),
      .vector_i   (vector_w),
      .priv_o     (priv_w),
      .saved_pc_o (saved_pc),
      .redirect_o (redirect),
      .target_o   (redirect_target)
   );

   assign priv_mode = priv_w;

   a_r2_target_fields: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid |=> (redirect_target[XLEN-1 -: BASE_W] == $past(base_w)
                      && redirect_target[SLOT_LSB-1:0] == '0
                      && redirect_target[SLOT_LSB +: NUM_W] == $past(trap_num_w)));

   a_r11_write_follows_old_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid && base_wr_en && !priv_w) |=> (priv_violation && priv_mode));
endmodule

// File: tb/sim_trap_vector_unit.sv
`timescale 1ns/1ps
module sim_trap_vector_unit;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        trap_valid;
   logic [31:0] trap_operand;
   logic [12:0] trap_imm;
   logic [31:0] trap_pc;
   logic        base_wr_en;
   logic [31:0] base_wr_data;
   logic        rett_valid;
   logic        redirect;
   logic [31:0] redirect_target;
   logic        priv_mode;
   logic [31:0] saved_pc;
   logic        priv_violation;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // model state
   logic [19:0] m_base;
   logic        m_priv;
   logic [31:0] m_saved;

   always #2.5 clk = ~clk;

   trap_vector_unit u0 (
      .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_operand(trap_operand),
      .trap_imm(trap_imm), .trap_pc(trap_pc), .base_wr_en(base_wr_en),
      .base_wr_data(base_wr_data), .rett_valid(rett_valid), .redirect(redirect),
      .redirect_target(redirect_target), .priv_mode(priv_mode), .saved_pc(saved_pc),
      .priv_violation(priv_violation)
   );

   function automatic logic [31:0] vec_of(input logic [19:0] b, input logic [31:0] op,
                                          input logic [12:0] im);
      logic [31:0] sum;
      sum = op + {{19{im[12]}}, im};
      return {b, 1'b0, sum[6:0], 4'b0000};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle_inputs();
      trap_valid = 0; trap_operand = '0; trap_imm = '0; trap_pc = '0;
      base_wr_en = 0; base_wr_data = '0; rett_valid = 0;
   endtask

   // Applies one cycle of stimulus (called at a falling edge), checks all outputs
   // at the following falling edge and advances the model.
   task automatic step(input string req, input logic t, input logic r, input logic w,
                       input logic [31:0] wd, input logic [31:0] op,
                       input logic [12:0] im, input logic [31:0] pc);
      logic        e_redir;
      logic [31:0] e_tgt;
      logic        e_viol;
      logic        take_ret;
      trap_valid = t; rett_valid = r; base_wr_en = w; base_wr_data = wd;
      trap_operand = op; trap_imm = im; trap_pc = pc;
      take_ret = r && !t && m_priv;
      e_redir  = t || take_ret;
      e_tgt    = t ? vec_of(m_base, op, im) : m_saved;
      e_viol   = w && !m_priv;
      if (w && m_priv) m_base = wd[31:12];
      if (t) begin
         m_saved = pc + 32'd4;
         m_priv  = 1'b1;
      end else if (take_ret) begin
         m_priv = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      check({req, " redirect"}, {31'b0, redirect}, {31'b0, e_redir});
      if (e_redir) check({req, " target"}, redirect_target, e_tgt);
      check({req, " priv_mode"}, {31'b0, priv_mode}, {31'b0, m_priv});
      check({req, " saved_pc"}, saved_pc, m_saved);
      check({req, " priv_violation"}, {31'b0, priv_violation}, {31'b0, e_viol});
      idle_inputs();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5eed_1234);
      idle_inputs();
      rst_n = 0;
      m_base = '0; m_priv = 1'b1; m_saved = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check("R1 priv_mode", {31'b0, priv_mode}, 32'd1);
      check("R1 redirect", {31'b0, redirect}, 32'd0);
      check("R1 priv_violation", {31'b0, priv_violation}, 32'd0);
      step("R1 zero base trap", 1, 0, 0, 0, 32'd5, 13'd0, 32'h100);
      check("R1 vector N*16", redirect_target, 32'h0000_0050);

      // R3 pulse ends
      step("R3 idle after trap", 0, 0, 0, 0, 0, 0, 0);

      // R6 privileged write, low bits discarded
      step("R6 write", 0, 0, 1, 32'hABCDE_FFF, 0, 0, 0);
      step("R6 trap new base", 1, 0, 0, 0, 32'd3, 13'd2, 32'h2000);
      check("R2 target with base", redirect_target, 32'hABCDE_050);

      // R2 negative immediate wraps: 0 + (-1) -> 0x7F
      step("R2 wrap negative", 1, 0, 0, 0, 32'd0, 13'h1FFF, 32'h3000);
      check("R2 num 0x7F", redirect_target, 32'hABCDE_7F0);
      // R2 carry out of bit 6 dropped: 0x7F + 1 -> 0
      step("R2 wrap carry", 1, 0, 0, 0, 32'hFFFF_FF7F, 13'd1, 32'h3004);
      check("R2 num 0", redirect_target, 32'hABCDE_000);

      // R8 return to user
      step("R8 return", 0, 1, 0, 0, 0, 0, 0);
      check("R8 target saved", redirect_target, 32'h3008);
      // R9 return in user ignored
      step("R9 user return", 0, 1, 0, 0, 0, 0, 0);
      // R7 user write refused
      step("R7 user write", 0, 0, 1, 32'h1111_1000, 0, 0, 0);
      step("R7 flag clears", 0, 0, 0, 0, 0, 0, 0);
      // R11 trap + write in user: old base used, write refused
      step("R11 trap with user write", 1, 0, 1, 32'h2222_2000, 32'd1, 13'd0, 32'h4000);
      check("R11 old base", redirect_target, 32'hABCDE_010);
      // R10 trap + return together
      step("R10 trap beats return", 1, 1, 0, 0, 32'd2, 13'd0, 32'h5000);
      check("R10 priv stays", {31'b0, priv_mode}, 32'd1);
      // R11 trap + write in privileged: write takes, old base for this trap
      step("R11 trap with priv write", 1, 0, 1, 32'h3333_3000, 32'd4, 13'd0, 32'h6000);
      check("R11 old base priv", redirect_target, 32'hABCDE_040);
      step("R6 base now new", 1, 0, 0, 0, 32'd4, 13'd0, 32'h6100);
      check("R6 new base used", redirect_target, 32'h33333_040);

      // R4 trap from user mode enters priv
      step("R8 back to user", 0, 1, 0, 0, 0, 0, 0);
      step("R4 trap from user", 1, 0, 0, 0, 32'd9, 13'd0, 32'h7000);

      // random mix, R2..R11
      for (int i = 0; i < 600; i++) begin
         logic t, r, w;
         t = ($urandom % 4) == 0;
         r = ($urandom % 4) == 0;
         w = ($urandom % 5) == 0;
         step("R2-mix random", t, r, w, $urandom, $urandom, 13'($urandom), $urandom & 32'hFFFF_FFFC);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule